// File: doc/BRIEF.md
# Parallel printer port transmitter

This block is the host end of a classic eight-bit parallel printer link. Characters arrive from the system over a valid/ready handshake. The block puts each character on an output data bus and pulses an active-low strobe line. It then waits for the printer's reply on two inputs: an active-low acknowledge and an active-high busy. Each character moves through a fixed order of steps: the previous acknowledge must be released, the data goes out, a setup delay runs, busy must be clear, strobe is asserted, the acknowledge arrives, strobe is released, and a hold delay runs. Because the next step never starts early, no character is overwritten while the printer still needs it.

Both printer inputs pass through a synchronizer before the sequencer reads them. Three counts are set at run time as plain inputs: the setup delay, the hold delay and the timeout. If the printer fails to answer within the timeout, the block releases strobe, raises a sticky error flag and returns to idle. A clear input resets the flag.

Top module: `pp_tx`

## Requirements
- R1: While reset is held, and in the first cycle after it, strobe is high, the data bus is zero, ready is high and the error flag is low.
- R2: Ready is high only while the block is idle. A character is taken on a clock edge where valid and ready are both high, and ready is low from the next cycle until the transfer ends.
- R3: The data bus does not change while the acknowledge input is low. If acknowledge is already high when the character is taken, the bus shows the character one cycle after the accepting edge. Otherwise it shows the character three cycles after acknowledge is released.
- R4: With busy low, strobe falls exactly max(S,1)+1 cycles after the data bus changes, where S is the setup count.
- R5: Strobe does not fall while the synchronized busy is high. If busy is released after the setup delay has run, strobe falls three cycles after the release.
- R6: Strobe stays low until the acknowledge input goes low, and it rises three cycles after that input falls. The data bus does not change while strobe is low.
- R7: Ready returns high exactly max(H,1) cycles after strobe rises, where H is the hold count. The data bus keeps the character through that interval.
- R8: If acknowledge does not arrive, strobe is released after max(T,1) cycles low, where T is the timeout count. In the same cycle the error flag is set and the block is idle again.
- R9: If busy stays high, or acknowledge stays low, the wait before strobe ends after max(T,1) cycles. The error flag is then set, strobe never falls, and in the acknowledge case the bus keeps the previous character.
- R10: The error flag stays set until the clear input is high at a clock edge. It is low in the following cycle, unless a new timeout occurs on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Character from the system |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block is idle and takes a character |
| pr_data | output | DATA_W | Data bus to the printer |
| pr_strobe_n | output | 1 | Strobe to the printer, active low |
| pr_ack_n | input | 1 | Acknowledge from the printer, active low, asynchronous |
| pr_busy | input | 1 | Busy from the printer, active high, asynchronous |
| setup_cycles | input | CNT_W | Setup delay between data and strobe |
| hold_cycles | input | CNT_W | Hold delay after strobe is released |
| timeout_cycles | input | CNT_W | Limit on each wait for the printer |
| err_clear | input | 1 | Clears the error flag |
| err_flag | output | 1 | Sticky timeout indication |

## Verification
Every printer input is synchronized, so each printer event reaches an output three edges after the negative edge where the bench drives it: two synchronizer stages plus the state register. A new data bus value appears one edge after acceptance. Strobe falls max(S,1)+1 edges after the data changes, ready returns max(H,1) edges after strobe rises, and a timeout fires max(T,1) edges after the wait begins. The bench samples only at negative edges and keeps a count of rising edges. It records the cycle in which each output first changes and compares it with the value it works out from these formulas, while sweeping the setup and hold counts and mixing in late acknowledges and late busy releases.

// File: rtl/pp_pkg.sv
package pp_pkg;

    // Sequencer states, listed in the order one transfer walks through them
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WAIT_ACK  = 3'd1,
        ST_SETUP     = 3'd2,
        ST_WAIT_BUSY = 3'd3,
        ST_STROBE    = 3'd4,
        ST_HOLD      = 3'd5
    } pp_state_e;

    // Printer reply lines, as seen on the pins and after the synchronizer
    typedef struct packed {
        logic ack_n;
        logic busy;
    } pp_line_t;

    localparam int LINE_W = $bits(pp_line_t);

    // Reset value of the synchronizer: acknowledge released, busy clear
    localparam logic [LINE_W-1:0] LINE_IDLE = 2'b10;

    // States in which the block waits on the printer and the timeout applies
    function automatic logic waits_on_printer(input pp_state_e s);
        return (s == ST_WAIT_ACK) || (s == ST_WAIT_BUSY) || (s == ST_STROBE);
    endfunction

    // States in which the strobe line is pulled low
    function automatic logic strobe_asserted(input pp_state_e s);
        return s == ST_STROBE;
    endfunction

endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
    parameter int          WIDTH   = 2,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // One flop chain per line
    for (genvar b = 0; b < WIDTH; b++) begin : g_line
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= {STAGES{RST_VAL[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], d[b]};
            end
        end

        assign q[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/pp_timer.sv
module pp_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] count_q;
    logic [EXT_W-1:0] count_next;

    // Counts cycles spent in the current state and saturates at all ones
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count_q <= '0;
        end else if (count_q != {CNT_W{1'b1}}) begin
            count_q <= count_q + 1'b1;
        end
    end

    // The current cycle is the last one once count+1 reaches the limit,
    // so a limit of zero behaves like a limit of one
    assign count_next = EXT_W'(count_q) + EXT_W'(1);
    assign done       = count_next >= EXT_W'(limit);

endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
    import pp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             ack_n_s,
    input  logic             busy_s,
    input  logic             tmr_done,
    input  logic [CNT_W-1:0] setup_cycles,
    input  logic [CNT_W-1:0] hold_cycles,
    input  logic [CNT_W-1:0] timeout_cycles,
    output logic             in_ready,
    output logic             accept,
    output logic             load_bus,
    output logic             abort,
    output logic             tmr_clr,
    output logic [CNT_W-1:0] tmr_limit,
    output logic             strobe_n
);

    pp_state_e state_q, state_d;
    logic      strobe_n_q;

    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        load_bus = 1'b0;
        abort    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    accept  = 1'b1;
                    state_d = ST_WAIT_ACK;
                end
            end
            ST_WAIT_ACK: begin
                if (ack_n_s) begin
                    load_bus = 1'b1;
                    state_d  = ST_SETUP;
                end else if (tmr_done) begin
                    abort = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    state_d = ST_WAIT_BUSY;
                end
            end
            ST_WAIT_BUSY: begin
                if (!busy_s) begin
                    state_d = ST_STROBE;
                end else if (tmr_done) begin
                    abort = 1'b1;
                end
            end
            ST_STROBE: begin
                if (!ack_n_s) begin
                    state_d = ST_HOLD;
                end else if (tmr_done) begin
                    abort = 1'b1;
                end
            end
            ST_HOLD: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (abort) begin
            state_d = ST_IDLE;
        end
    end

    // The counter restarts on every state change
    assign tmr_clr = (state_d != state_q);

    always_comb begin
        if (waits_on_printer(state_q)) begin
            tmr_limit = timeout_cycles;
        end else if (state_q == ST_SETUP) begin
            tmr_limit = setup_cycles;
        end else begin
            tmr_limit = hold_cycles;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            strobe_n_q <= 1'b1;
        end else begin
            state_q    <= state_d;
            strobe_n_q <= !strobe_asserted(state_d);
        end
    end

    assign in_ready = (state_q == ST_IDLE);
    assign strobe_n = strobe_n_q;

endmodule

// File: rtl/pp_tx.sv
module pp_tx
    import pp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] pr_data,
    output logic              pr_strobe_n,
    input  logic              pr_ack_n,
    input  logic              pr_busy,
    input  logic [CNT_W-1:0]  setup_cycles,
    input  logic [CNT_W-1:0]  hold_cycles,
    input  logic [CNT_W-1:0]  timeout_cycles,
    input  logic              err_clear,
    output logic              err_flag
);

    pp_line_t          line_raw, line_sync;
    logic              ack_n_sync, busy_sync;
    logic              accept, load_bus, abort;
    logic              tmr_clr, tmr_done;
    logic [CNT_W-1:0]  tmr_limit;
    logic [DATA_W-1:0] char_q, bus_q;
    logic              err_q;

    assign line_raw = '{ack_n: pr_ack_n, busy: pr_busy};

    pp_sync #(
        .WIDTH  (LINE_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(LINE_IDLE)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (line_raw),
        .q  (line_sync)
    );

    assign ack_n_sync = line_sync.ack_n;
    assign busy_sync  = line_sync.busy;

    pp_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .clr  (tmr_clr),
        .limit(tmr_limit),
        .done (tmr_done)
    );

    pp_ctrl #(
        .CNT_W(CNT_W)
    ) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .ack_n_s       (ack_n_sync),
        .busy_s        (busy_sync),
        .tmr_done      (tmr_done),
        .setup_cycles  (setup_cycles),
        .hold_cycles   (hold_cycles),
        .timeout_cycles(timeout_cycles),
        .in_ready      (in_ready),
        .accept        (accept),
        .load_bus      (load_bus),
        .abort         (abort),
        .tmr_clr       (tmr_clr),
        .tmr_limit     (tmr_limit),
        .strobe_n      (pr_strobe_n)
    );

    // Character buffer, output bus and sticky error flag
    always_ff @(posedge clk) begin
        if (rst) begin
            char_q <= '0;
            bus_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            if (accept) begin
                char_q <= in_data;
            end
            if (load_bus) begin
                bus_q <= char_q;
            end
            if (abort) begin
                err_q <= 1'b1;
            end else if (err_clear) begin
                err_q <= 1'b0;
            end
        end
    end

    assign pr_data  = bus_q;
    assign err_flag = err_q;

endmodule

// File: rtl/pp_tx_chk.sv
module pp_tx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] pr_data,
    input logic              pr_strobe_n,
    input logic              err_flag,
    input logic              err_clear,
    input logic              ack_n_s,
    input logic              busy_s
);

    // R2: strobe is never low while the block offers ready
    p_idle_strobe_high_r2: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> pr_strobe_n);

    // R2: an accepted character takes the block out of idle
    p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R3: the bus changes only while strobe is high
    p_bus_moves_strobe_high_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(pr_data) |-> pr_strobe_n);

    // R5: strobe falls only after busy was seen low
    p_fall_needs_busy_low_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(pr_strobe_n) |-> !$past(busy_s));

    // R6: strobe rises only on acknowledge or on a timeout
    p_rise_needs_ack_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pr_strobe_n) |-> (!$past(ack_n_s) || err_flag));

    // R6: the bus holds still while strobe is low
    p_bus_stable_strobe_low_r6: assert property (@(posedge clk) disable iff (rst)
        !pr_strobe_n |-> $stable(pr_data));

    // R10: the error flag only goes away through the clear input
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !err_clear) |=> err_flag);

endmodule

bind pp_tx pp_tx_chk #(
    .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .pr_data    (pr_data),
    .pr_strobe_n(pr_strobe_n),
    .err_flag   (err_flag),
    .err_clear  (err_clear),
    .ack_n_s    (ack_n_sync),
    .busy_s     (busy_sync)
);

// File: tb/pp_tx_test.sv
module pp_tx_test;

    localparam int DW = 8;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] pr_data;
    logic          pr_strobe_n;
    logic          pr_ack_n = 1'b1;
    logic          pr_busy = 1'b0;
    logic [CW-1:0] setup_cycles = CW'(1);
    logic [CW-1:0] hold_cycles = CW'(1);
    logic [CW-1:0] timeout_cycles = CW'(1000);
    logic          err_clear = 1'b0;
    logic          err_flag;

    int            cyc = 0;
    int            total = 0;
    int            bad = 0;
    logic [DW-1:0] last_ch = '0;

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    pp_tx #(.DATA_W(DW), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .pr_data(pr_data), .pr_strobe_n(pr_strobe_n),
        .pr_ack_n(pr_ack_n), .pr_busy(pr_busy), .setup_cycles(setup_cycles),
        .hold_cycles(hold_cycles), .timeout_cycles(timeout_cycles),
        .err_clear(err_clear), .err_flag(err_flag)
    );

    task automatic check(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic int at_least1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    // One complete transfer with an answering printer
    task automatic xfer(input logic [DW-1:0] ch, input int s, input int h,
                        input int ackd, input int stale, input int bext);
        int e0, td, tf, ta, tr, tq, k, b, exp_f;
        k = 0;
        b = 0;
        setup_cycles = CW'(s);
        hold_cycles  = CW'(h);
        while (!in_ready) step();
        if (stale > 0) begin
            pr_ack_n = 1'b0;
            repeat (3) step();
        end
        if (bext > 0) begin
            pr_busy = 1'b1;
            repeat (3) step();
        end
        in_data  = ch;
        in_valid = 1'b1;
        step();
        e0       = cyc;
        in_valid = 1'b0;
        check("R2 ready low after accept", int'(in_ready), 0);
        if (stale > 0) begin
            repeat (stale) step();
            check("R3 bus held while ack low", int'(pr_data), int'(last_ch));
            k        = cyc;
            pr_ack_n = 1'b1;
        end
        while (pr_data != ch) step();
        td = cyc;
        check("R3 bus change cycle", td, (stale > 0) ? k + 3 : e0 + 1);
        if (bext > 0) begin
            repeat (bext) step();
            check("R5 strobe high while busy", int'(pr_strobe_n), 1);
            b       = cyc;
            pr_busy = 1'b0;
        end
        while (pr_strobe_n) step();
        tf    = cyc;
        exp_f = td + at_least1(s) + 1;
        if (bext > 0 && b + 3 > exp_f) exp_f = b + 3;
        check((bext > 0) ? "R5 strobe fall after busy" : "R4 strobe fall after setup",
              tf, exp_f);
        repeat (ackd) step();
        check("R6 strobe low until ack", int'(pr_strobe_n), 0);
        ta       = cyc;
        pr_ack_n = 1'b0;
        while (!pr_strobe_n) step();
        tr = cyc;
        check("R6 strobe rise cycle", tr, ta + 3);
        check("R6 bus held at strobe rise", int'(pr_data), int'(ch));
        pr_ack_n = 1'b1;
        pr_busy  = 1'b1;
        while (!in_ready) step();
        tq = cyc;
        check("R7 ready return cycle", tq, tr + at_least1(h));
        check("R7 bus kept through hold", int'(pr_data), int'(ch));
        pr_busy = 1'b0;
        repeat (3) step();
        last_ch = ch;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL all watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int e0, td, tf, tr, te, lows;
        logic [DW-1:0] ch;

        repeat (3) step();
        check("R1 strobe in reset", int'(pr_strobe_n), 1);
        check("R1 bus in reset", int'(pr_data), 0);
        rst = 1'b0;
        step();
        check("R1 strobe after reset", int'(pr_strobe_n), 1);
        check("R1 bus after reset", int'(pr_data), 0);
        check("R1 ready after reset", int'(in_ready), 1);
        check("R1 error after reset", int'(err_flag), 0);

        // Sweep setup and hold counts with mixed printer timing
        for (int s = 0; s <= 4; s++) begin
            for (int h = 0; h <= 3; h++) begin
                int i;
                i  = s * 4 + h;
                ch = DW'(i * 37 + 5);
                xfer(ch, s, h, (s + h) % 3, (i % 4 == 1) ? 2 + s : 0,
                     (i % 3 == 2) ? 1 + h * 2 : 0);
            end
        end

        // R8: acknowledge never comes
        setup_cycles   = CW'(1);
        timeout_cycles = CW'(6);
        ch       = 8'hA6;
        in_data  = ch;
        in_valid = 1'b1;
        step();
        in_valid = 1'b0;
        while (pr_strobe_n) step();
        tf = cyc;
        while (!pr_strobe_n) step();
        tr = cyc;
        check("R8 strobe low length", tr - tf, 6);
        check("R8 error set at release", int'(err_flag), 1);
        check("R8 idle after timeout", int'(in_ready), 1);
        repeat (5) step();
        check("R10 error sticky", int'(err_flag), 1);
        err_clear = 1'b1;
        step();
        err_clear = 1'b0;
        check("R10 error cleared", int'(err_flag), 0);
        last_ch = ch;

        // R9: busy stuck high
        pr_busy = 1'b1;
        repeat (3) step();
        timeout_cycles = CW'(5);
        ch       = 8'h5C;
        in_data  = ch;
        in_valid = 1'b1;
        step();
        in_valid = 1'b0;
        while (pr_data != ch) step();
        td   = cyc;
        lows = 0;
        while (!err_flag) begin
            if (!pr_strobe_n) lows++;
            step();
        end
        te = cyc;
        check("R9 busy timeout cycle", te, td + 1 + 5);
        check("R9 no strobe while busy", lows, 0);
        check("R9 strobe high after busy timeout", int'(pr_strobe_n), 1);
        pr_busy   = 1'b0;
        err_clear = 1'b1;
        step();
        err_clear = 1'b0;
        repeat (3) step();
        last_ch = ch;

        // R9: acknowledge stuck low before the transfer
        pr_ack_n = 1'b0;
        repeat (3) step();
        timeout_cycles = CW'(4);
        in_data  = 8'h3E;
        in_valid = 1'b1;
        step();
        e0       = cyc;
        in_valid = 1'b0;
        while (!err_flag) step();
        te = cyc;
        check("R9 ack timeout cycle", te, e0 + 4);
        check("R9 bus keeps previous char", int'(pr_data), int'(last_ch));
        check("R9 idle after ack timeout", int'(in_ready), 1);
        pr_ack_n  = 1'b1;
        err_clear = 1'b1;
        step();
        err_clear = 1'b0;
        check("R10 clear after ack timeout", int'(err_flag), 0);
        repeat (3) step();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule